// File: doc/BRIEF.md
# Post-Reset ECC Memory Scrubber

This block wraps a single-port RAM whose every word carries eight data bits plus five check bits of a single-error-correcting, double-error-detecting Hamming code. Each time reset is released, a sequencer sweeps the whole array once. For each address it reads the stored codeword, decodes it, and writes the repaired codeword back to that address. Words that need no repair are not written. Words with two flipped bits cannot be repaired. They are counted and left as they are.

While the sweep runs, the user port is locked out. When the last address has been handled, `init_done` goes high and the port opens. From then on, writes are encoded on the way in and reads are corrected on the way out. The port carries a codeword flip mask so that known faults can be planted in stored words. Two saturating counters report how many words the last sweep repaired and how many it found beyond repair. The array is not cleared by reset, so whatever it holds survives into the next sweep.

Top module: `mem_scrub`

## Requirements
- R1: After reset is released, `init_done` is low. It rises exactly 2*DEPTH clock cycles after the first rising edge at which reset is low, and it stays high until reset is asserted again.
- R2: A stored word is a 13-bit SECDED codeword (Hamming positions 1..12 plus an overall parity bit at index 0). Bit i of `usr_flip` inverts codeword bit i (0..12) as the word is written.
- R3: While `init_done` is low, the user port has no effect. Writes do not change the array, and reads never raise `usr_rvalid`.
- R4: During the sweep, each address takes one read cycle followed by one write-back cycle at the same address. A word with a single-bit error is rewritten in corrected form, so a following sweep finds it clean.
- R5: Clean words and words with a double-bit error are not rewritten. A double-bit error is still present on the next sweep.
- R6: `corr_count` is cleared by reset and counts the words the sweep corrected. It saturates at 2^CNT_W-1.
- R7: `uncorr_count` is cleared by reset and counts the words found with an uncorrectable error. It saturates at 2^CNT_W-1.
- R8: Once `init_done` is high, a read returns the corrected data byte on `usr_rdata` with `usr_rvalid` high one cycle after the request. `usr_rd_uncorr` flags a double-bit error in that word.
- R9: Reset does not clear the array. Data written before a reset reads back unchanged after the next sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a new sweep |
| usr_en | input | 1 | User access request (honoured only after `init_done`) |
| usr_we | input | 1 | 1 = write, 0 = read |
| usr_addr | input | ADDR_W | User word address |
| usr_wdata | input | 8 | User write data byte |
| usr_flip | input | 13 | Codeword bits to invert on write (fault planting) |
| usr_rdata | output | 8 | Corrected read data |
| usr_rvalid | output | 1 | Read data valid, one cycle after a read request |
| usr_rd_uncorr | output | 1 | Read word held an uncorrectable error |
| init_done | output | 1 | Sweep finished; user port open |
| corr_count | output | CNT_W | Words corrected by the last sweep (saturating) |
| uncorr_count | output | CNT_W | Uncorrectable words seen by the last sweep (saturating) |

## Verification
Properties are checked on every cycle:
- `init_done` is sticky until reset, and it follows the write-back of the last address.
- Both counters never decrease within a sweep.
- A sweep write-back always lands on the address read in the cycle before.
- No read-valid appears before the port opens.

Other behaviour can only be shown by the directed scenarios:
- That a repaired word really is clean on a second sweep, while a double-bit fault survives it.
- That blocked writes leave the data intact.
- That the corrected counter stops at its ceiling.
- That data survives reset.

// File: rtl/mem_scrub_pkg.sv
package mem_scrub_pkg;

    localparam int DATA_W = 8;
    localparam int CW_W   = 13;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CW_W-1:0]   fixed;
        logic              single;
        logic              double;
    } dec_t;

    // place data bits on non-power-of-two positions, then fill parity
    function automatic logic [CW_W-1:0] secded_enc(input logic [DATA_W-1:0] d);
        logic [CW_W-1:0] cw;
        int k;
        cw = '0;
        k  = 0;
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < 4; b++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p < CW_W; p++) begin
                if (p[b]) x = x ^ cw[p];
            end
            cw[1 << b] = x;
        end
        cw[0] = ^cw[CW_W-1:1];
        return cw;
    endfunction

    function automatic logic [DATA_W-1:0] secded_data(input logic [CW_W-1:0] cw);
        logic [DATA_W-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[k] = cw[p];
                k++;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/scrub_ram.sv
module scrub_ram #(
    parameter int DEPTH  = 32,
    parameter int WIDTH  = 13,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    // contents are deliberately not reset
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem_q[addr] <= wdata;
            else    rdata_q     <= mem_q[addr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/scrub_dec.sv
module scrub_dec
    import mem_scrub_pkg::*;
(
    input  logic [CW_W-1:0] cw,
    output dec_t            dec
);
    logic [3:0] syn;
    logic       ovp;

    always_comb begin
        syn = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (cw[p]) syn = syn ^ 4'(p);
        end
        ovp        = ^cw;
        dec.fixed  = cw;
        dec.single = 1'b0;
        dec.double = 1'b0;
        if (ovp) begin
            if (syn <= 4'd12) begin
                dec.fixed[syn] = ~cw[syn];
                dec.single     = 1'b1;
            end else begin
                dec.double = 1'b1;
            end
        end else if (syn != '0) begin
            dec.double = 1'b1;
        end
        dec.data = secded_data(dec.fixed);
    end
endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
    import mem_scrub_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int CNT_W  = 4,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  dec_t              dec_i,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [CW_W-1:0]   ram_wdata,
    output logic              done,
    output logic [CNT_W-1:0]  corr_cnt,
    output logic [CNT_W-1:0]  uncorr_cnt
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    typedef enum logic [1:0] {PH_READ, PH_WB, PH_DONE} phase_e;

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  corr;
        logic [CNT_W-1:0]  uncorr;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_wdata = dec_i.fixed;
        case (s_q.phase)
            PH_READ: begin
                ram_en    = 1'b1;
                s_d.phase = PH_WB;
            end
            PH_WB: begin
                if (dec_i.single) begin
                    ram_en = 1'b1;
                    ram_we = 1'b1;
                    if (s_q.corr != '1) s_d.corr = s_q.corr + 1'b1;
                end
                if (dec_i.double && s_q.uncorr != '1)
                    s_d.uncorr = s_q.uncorr + 1'b1;
                if (s_q.addr == LAST) begin
                    s_d.phase = PH_DONE;
                end else begin
                    s_d.addr  = s_q.addr + 1'b1;
                    s_d.phase = PH_READ;
                end
            end
            default: ;
        endcase
        if (rst) s_d = '{phase: PH_READ, addr: '0, corr: '0, uncorr: '0};
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign ram_addr   = s_q.addr;
    assign done       = (s_q.phase == PH_DONE);
    assign corr_cnt   = s_q.corr;
    assign uncorr_cnt = s_q.uncorr;

    // R1: once open, the port stays open until reset
    p_done_sticky_r1: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R1: the last write-back step is followed by completion
    p_done_after_last_r1: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_WB && s_q.addr == LAST) |=> done);

    // R6: the corrected count never falls within a sweep
    p_corr_monotone_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> corr_cnt >= $past(corr_cnt));

    // R7: the uncorrectable count never falls within a sweep
    p_uncorr_monotone_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> uncorr_cnt >= $past(uncorr_cnt));
endmodule

// File: rtl/mem_scrub.sv
module mem_scrub
    import mem_scrub_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int CNT_W  = 4,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              usr_en,
    input  logic              usr_we,
    input  logic [ADDR_W-1:0] usr_addr,
    input  logic [7:0]        usr_wdata,
    input  logic [12:0]       usr_flip,
    output logic [7:0]        usr_rdata,
    output logic              usr_rvalid,
    output logic              usr_rd_uncorr,
    output logic              init_done,
    output logic [CNT_W-1:0]  corr_count,
    output logic [CNT_W-1:0]  uncorr_count
);
    dec_t              dec;
    logic [CW_W-1:0]   ram_rdata;
    logic              sc_en, sc_we;
    logic [ADDR_W-1:0] sc_addr;
    logic [CW_W-1:0]   sc_wdata;
    logic              ram_en, ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [CW_W-1:0]   ram_wdata;
    logic              rvalid_d, rvalid_q;

    scrub_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .dec_i(dec),
        .ram_en(sc_en), .ram_we(sc_we), .ram_addr(sc_addr), .ram_wdata(sc_wdata),
        .done(init_done), .corr_cnt(corr_count), .uncorr_cnt(uncorr_count)
    );

    scrub_dec u_dec (.cw(ram_rdata), .dec(dec));

    scrub_ram #(.DEPTH(DEPTH), .WIDTH(CW_W)) u_ram (
        .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
        .wdata(ram_wdata), .rdata(ram_rdata)
    );

    always_comb begin
        if (init_done) begin
            ram_en    = usr_en;
            ram_we    = usr_en & usr_we;
            ram_addr  = usr_addr;
            ram_wdata = secded_enc(usr_wdata) ^ usr_flip;
        end else begin
            ram_en    = sc_en;
            ram_we    = sc_we;
            ram_addr  = sc_addr;
            ram_wdata = sc_wdata;
        end
        rvalid_d = init_done & usr_en & ~usr_we & ~rst;
    end

    always_ff @(posedge clk) begin
        rvalid_q <= rvalid_d;
    end

    assign usr_rvalid    = rvalid_q;
    assign usr_rdata     = dec.data;
    assign usr_rd_uncorr = rvalid_q & dec.double;

    // R3: no read data is handed out before the port opens
    p_rvalid_gated_r3: assert property (@(posedge clk) disable iff (rst)
        usr_rvalid |-> $past(init_done));

    // R4: a sweep write lands on the address read just before
    p_wb_same_addr_r4: assert property (@(posedge clk) disable iff (rst)
        (!init_done && ram_we) |-> ($past(ram_en) && !$past(ram_we)
                                    && ram_addr == $past(ram_addr)));
endmodule

// File: tb/mem_scrub_bench.sv
`timescale 1ns/1ps
module mem_scrub_bench;
    localparam int DEPTH  = 32;
    localparam int CNT_W  = 4;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              usr_en = 1'b0, usr_we = 1'b0;
    logic [ADDR_W-1:0] usr_addr = '0;
    logic [7:0]        usr_wdata = '0;
    logic [12:0]       usr_flip = '0;
    logic [7:0]        usr_rdata;
    logic              usr_rvalid, usr_rd_uncorr, init_done;
    logic [CNT_W-1:0]  corr_count, uncorr_count;

    int n_chk = 0, n_fail = 0;

    mem_scrub #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_mem_scrub (
        .clk(clk), .rst(rst), .usr_en(usr_en), .usr_we(usr_we),
        .usr_addr(usr_addr), .usr_wdata(usr_wdata), .usr_flip(usr_flip),
        .usr_rdata(usr_rdata), .usr_rvalid(usr_rvalid), .usr_rd_uncorr(usr_rd_uncorr),
        .init_done(init_done), .corr_count(corr_count), .uncorr_count(uncorr_count)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reset, optionally hammer the port during the sweep; returns sweep length
    task automatic boot(input logic poke, output int cyc, output int early_rv);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 corr cleared", corr_count == 0, corr_count, 0);
        chk("R7 uncorr cleared", uncorr_count == 0, uncorr_count, 0);
        rst = 1'b0;
        if (poke) begin
            usr_en = 1'b1; usr_addr = ADDR_W'(5); usr_wdata = 8'hEE;
        end
        cyc = 0;
        early_rv = 0;
        while (!init_done && cyc < 1000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (usr_rvalid) early_rv++;
            if (poke) usr_we = ~usr_we;
        end
        usr_en = 1'b0; usr_we = 1'b0;
    endtask

    task automatic wr(input int a, input logic [7:0] d, input logic [12:0] f);
        @(negedge clk);
        usr_en = 1'b1; usr_we = 1'b1; usr_addr = ADDR_W'(a); usr_wdata = d; usr_flip = f;
        @(negedge clk);
        usr_en = 1'b0; usr_we = 1'b0; usr_flip = '0;
    endtask

    task automatic rd(input int a, output logic [7:0] d, output logic v, output logic u);
        @(negedge clk);
        usr_en = 1'b1; usr_we = 1'b0; usr_addr = ADDR_W'(a);
        @(negedge clk);
        usr_en = 1'b0;
        d = usr_rdata; v = usr_rvalid; u = usr_rd_uncorr;
    endtask

    task automatic fill_clean();
        for (int a = 0; a < DEPTH; a++) wr(a, pat(a), '0);
    endtask

    task automatic t_timing();
        int cyc, erv;
        boot(1'b0, cyc, erv);
        chk("R1 sweep length", cyc == 2 * DEPTH, cyc, 2 * DEPTH);
        repeat (5) @(negedge clk);
        chk("R1 done stays high", init_done == 1'b1, init_done, 1);
    endtask

    task automatic t_blocked();
        int cyc, erv;
        logic [7:0] d; logic v, u;
        boot(1'b1, cyc, erv);
        chk("R3 no rvalid during sweep", erv == 0, erv, 0);
        chk("R5 clean pass no corrections", corr_count == 0, corr_count, 0);
        rd(5, d, v, u);
        chk("R3 blocked write ignored", d == pat(5), d, pat(5));
        rd(9, d, v, u);
        chk("R9 data kept over reset", d == pat(9) && v, d, pat(9));
    endtask

    task automatic t_roundtrip();
        logic [7:0] d; logic v, u;
        logic [7:0] vals [4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
        for (int i = 0; i < 4; i++) begin
            wr(30, vals[i], '0);
            rd(30, d, v, u);
            chk("R8 roundtrip data", d == vals[i], d, vals[i]);
            chk("R8 rvalid and clean flag", v && !u, {v, u}, 2);
        end
        wr(30, pat(30), '0);
    endtask

    task automatic t_errors();
        int cyc, erv;
        logic [7:0] d; logic v, u;
        for (int a = 0; a < 13; a++) wr(a, pat(a), 13'(1 << a));
        wr(20, pat(20), 13'b0_0000_0000_0110);
        wr(21, pat(21), 13'b0_0000_1000_0001);
        rd(12, d, v, u);
        chk("R8 read corrects single", d == pat(12) && !u, d, pat(12));
        rd(20, d, v, u);
        chk("R8 double flagged on read", u == 1'b1, u, 1);
        boot(1'b0, cyc, erv);
        chk("R6 corrected singles counted", corr_count == 13, corr_count, 13);
        chk("R7 doubles counted", uncorr_count == 2, uncorr_count, 2);
        boot(1'b0, cyc, erv);
        chk("R4 singles rewritten clean", corr_count == 0, corr_count, 0);
        chk("R5 doubles left in place", uncorr_count == 2, uncorr_count, 2);
        rd(0, d, v, u);
        chk("R2 overall parity bit fault repaired", d == pat(0) && !u, d, pat(0));
        rd(7, d, v, u);
        chk("R4 repaired data", d == pat(7) && !u, d, pat(7));
    endtask

    task automatic t_saturate();
        int cyc, erv;
        for (int a = 0; a < 20; a++) wr(a, pat(a), 13'(1 << (a % 13)));
        boot(1'b0, cyc, erv);
        chk("R6 corrected count saturates", corr_count == 15, corr_count, 15);
        chk("R7 uncorr still counted", uncorr_count == 2, uncorr_count, 2);
        boot(1'b0, cyc, erv);
        chk("R4 all twenty repaired", corr_count == 0, corr_count, 0);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int cyc, erv;
        boot(1'b0, cyc, erv);
        fill_clean();
        t_timing();
        t_blocked();
        t_roundtrip();
        t_errors();
        t_saturate();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule